// File: doc/BRIEF.md
# UART Interrupt Cause Encoder

This block turns the separate status conditions of a serial port into a single interrupt request and an identification byte that software reads to find out why it was interrupted. Five conditions come in from the surrounding port logic:

- receiver line error
- receive data available
- character timeout
- transmit holding register empty
- modem-status change

A 4-bit enable value decides which of these may raise the request. The receiver, the FIFOs and the modem logic are outside this block.

Each condition is captured as a pending event on its rising edge. The event stays pending until the matching access strobe clears it:

- A line-status read clears a line-error event.
- A modem-status read clears a modem event.
- A receive-buffer read clears both the receive-data event and the timeout event.
- A holding-register write clears the holding-empty event. Reading the identification byte also clears it, but only while holding-empty is the reported cause.

When several events are pending, the one with the highest priority is reported.

Top module: `uart_irq_ident`

## Requirements
- R1: `irq_o` is 1 exactly when at least one event is pending and its enable bit is set. The enable bits are: bit 0 for receive data and timeout, bit 1 for holding-empty, bit 2 for line error, and bit 3 for modem change.
- R2: `iir_o[0]` is 0 while `irq_o` is 1, and 1 otherwise. After reset, `irq_o` is 0 and `iir_o` reads 0x01 when `fifo_en_i` is 0.
- R3: `iir_o[3:1]` gives the reported cause: 011 line error, 010 receive data, 110 timeout, 001 holding-empty, 000 modem change. It reads 000 when nothing is reported.
- R4: A line-status read strobe clears a pending line-error event. A modem-status read strobe clears a pending modem event.
- R5: A receive-buffer read strobe clears both the receive-data event and the timeout event.
- R6: Holding-empty is cleared by a holding-register write strobe. It is also cleared by an identification read strobe in a cycle where it is the reported cause.
- R7: `iir_o[7:6]` reads 11 when `fifo_en_i` is 1 and 00 when it is 0. `iir_o[5:4]` always reads 00.
- R8: The reporting priority is fixed: line error, then receive data, then timeout, then holding-empty, then modem change.
- R9: An event becomes pending in the cycle after its condition rises. It stays pending while its enable bit is off. A rise in the same cycle as a clear strobe leaves the event pending.
- R10: Holding-empty is also set when enable bit 1 goes from 0 to 1 while the holding-empty condition is already 1.
- R11: `iir_o` in the cycle that carries a strobe still shows the value from before that strobe. The clear takes effect in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_i | input | 4 | Interrupt enable bits |
| fifo_en_i | input | 1 | FIFOs enabled indication |
| lsr_err_i | input | 1 | Receiver line error condition |
| rx_avail_i | input | 1 | Receive data available condition |
| rx_timeout_i | input | 1 | Character timeout condition |
| thr_empty_i | input | 1 | Holding register empty condition |
| msr_delta_i | input | 1 | Modem status change condition |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| iir_rd_i | input | 1 | Identification byte read strobe |
| thr_wr_i | input | 1 | Holding register write strobe |
| irq_o | output | 1 | Interrupt request |
| iir_o | output | 8 | Identification byte |

## Verification
A lost or stuck pending event shows at the ports one cycle after the event's rise or clear strobe. It appears either as a wrong cause code in `iir_o[3:1]` or as a missing or spurious `irq_o`. The bench keeps its own event model and compares it with both outputs on every cycle, so a fault is caught within one clock. Priority and masking faults only appear when several events are pending at once. The directed sequence stacks events for that reason, and a long pseudo-random run of conditions and strobes covers the remaining combinations.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    // Cause codes placed in identification bits 3:1
    localparam logic [2:0] CAUSE_LINE = 3'b011;
    localparam logic [2:0] CAUSE_RXD  = 3'b010;
    localparam logic [2:0] CAUSE_TMO  = 3'b110;
    localparam logic [2:0] CAUSE_THR  = 3'b001;
    localparam logic [2:0] CAUSE_MDM  = 3'b000;

    // Index of each edge-latched event in the event vector
    localparam int EV_LINE = 0;
    localparam int EV_RXD  = 1;
    localparam int EV_TMO  = 2;
    localparam int EV_MDM  = 3;
    localparam int EV_NUM  = 4;

    // Enable bit positions
    localparam int EN_RX   = 0;
    localparam int EN_THR  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int EN_W    = 4;

endpackage

// File: rtl/uart_irq_evt.sv
module uart_irq_evt #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic [N-1:0] rise;

    // Per-event edge latch; a rise wins over a clear in the same cycle
    for (genvar i = 0; i < N; i++) begin : g_evt
        assign rise[i] = cond_i[i] & ~st_q.prev[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = cond_i;
        st_d.pend = rise | (st_q.pend & ~clr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uart_irq_thr.sv
module uart_irq_thr (
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic en_i,
    input  logic wr_i,
    input  logic id_rd_i,
    input  logic reported_i,
    output logic pend_o
);
    typedef struct packed {
        logic empty_prev;
        logic en_prev;
        logic pend;
    } thr_state_t;

    thr_state_t st_d, st_q;
    logic arm, clr;

    always_comb begin
        arm  = (empty_i & ~st_q.empty_prev) | (empty_i & en_i & ~st_q.en_prev);
        clr  = wr_i | (id_rd_i & reported_i);
        st_d            = st_q;
        st_d.empty_prev = empty_i;
        st_d.en_prev    = en_i;
        st_d.pend       = arm | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [EV_NUM-1:0] pend_i,
    input  logic              thr_pend_i,
    input  logic [EN_W-1:0]   en_i,
    input  logic              fifo_en_i,
    output logic              irq_o,
    output logic              thr_cause_o,
    output logic [7:0]        id_o
);
    logic [2:0] cause;
    logic       any;

    always_comb begin
        any         = 1'b1;
        cause       = CAUSE_MDM;
        thr_cause_o = 1'b0;
        if (pend_i[EV_LINE] && en_i[EN_LINE]) begin
            cause = CAUSE_LINE;
        end else if (pend_i[EV_RXD] && en_i[EN_RX]) begin
            cause = CAUSE_RXD;
        end else if (pend_i[EV_TMO] && en_i[EN_RX]) begin
            cause = CAUSE_TMO;
        end else if (thr_pend_i && en_i[EN_THR]) begin
            cause       = CAUSE_THR;
            thr_cause_o = 1'b1;
        end else if (pend_i[EV_MDM] && en_i[EN_MDM]) begin
            cause = CAUSE_MDM;
        end else begin
            any = 1'b0;
        end
        irq_o = any;
        id_o  = {{2{fifo_en_i}}, 2'b00, cause, ~any};
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] ier_i,
    input  logic       fifo_en_i,
    input  logic       lsr_err_i,
    input  logic       rx_avail_i,
    input  logic       rx_timeout_i,
    input  logic       thr_empty_i,
    input  logic       msr_delta_i,
    input  logic       rbr_rd_i,
    input  logic       lsr_rd_i,
    input  logic       msr_rd_i,
    input  logic       iir_rd_i,
    input  logic       thr_wr_i,
    output logic       irq_o,
    output logic [7:0] iir_o
);
    logic [EV_NUM-1:0] ev_cond, ev_clr, ev_pend;
    logic thr_pend, thr_cause;

    always_comb begin
        ev_cond          = '0;
        ev_clr           = '0;
        ev_cond[EV_LINE] = lsr_err_i;
        ev_cond[EV_RXD]  = rx_avail_i;
        ev_cond[EV_TMO]  = rx_timeout_i;
        ev_cond[EV_MDM]  = msr_delta_i;
        ev_clr[EV_LINE]  = lsr_rd_i;
        ev_clr[EV_RXD]   = rbr_rd_i;
        ev_clr[EV_TMO]   = rbr_rd_i;
        ev_clr[EV_MDM]   = msr_rd_i;
    end

    uart_irq_evt #(.N(EV_NUM)) evt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond_i (ev_cond),
        .clr_i  (ev_clr),
        .pend_o (ev_pend)
    );

    uart_irq_thr thr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .empty_i    (thr_empty_i),
        .en_i       (ier_i[EN_THR]),
        .wr_i       (thr_wr_i),
        .id_rd_i    (iir_rd_i),
        .reported_i (thr_cause),
        .pend_o     (thr_pend)
    );

    uart_irq_prio prio_i (
        .pend_i      (ev_pend),
        .thr_pend_i  (thr_pend),
        .en_i        (ier_i),
        .fifo_en_i   (fifo_en_i),
        .irq_o       (irq_o),
        .thr_cause_o (thr_cause),
        .id_o        (iir_o)
    );
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] ier_i,
    input logic       fifo_en_i,
    input logic       lsr_err_i,
    input logic       rx_avail_i,
    input logic       rx_timeout_i,
    input logic       thr_empty_i,
    input logic       msr_delta_i,
    input logic       rbr_rd_i,
    input logic       lsr_rd_i,
    input logic       msr_rd_i,
    input logic       thr_wr_i,
    input logic       irq_o,
    input logic [7:0] iir_o
);
    logic lerr_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lerr_prev_q <= 1'b0;
        else        lerr_prev_q <= lsr_err_i;
    end

    assert_id_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o != iir_o[0]);

    assert_fixed_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iir_o[7:4] == {fifo_en_i, fifo_en_i, 2'b00});

    assert_line_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd_i && !lsr_err_i) |=> iir_o[3:0] != 4'b0110);

    assert_mdm_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd_i && !msr_delta_i) |=> iir_o[3:0] != 4'b0000);

    assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd_i && !rx_avail_i && !rx_timeout_i)
            |=> (iir_o[3:0] != 4'b0100 && iir_o[3:0] != 4'b1100));

    assert_thr_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr_i && !thr_empty_i) |=> iir_o[3:0] != 4'b0010);

    assert_line_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_err_i && !lerr_prev_q && ier_i[2]) |=> (!ier_i[2] || iir_o[3:0] == 4'b0110));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ier_i        (ier_i),
    .fifo_en_i    (fifo_en_i),
    .lsr_err_i    (lsr_err_i),
    .rx_avail_i   (rx_avail_i),
    .rx_timeout_i (rx_timeout_i),
    .thr_empty_i  (thr_empty_i),
    .msr_delta_i  (msr_delta_i),
    .rbr_rd_i     (rbr_rd_i),
    .lsr_rd_i     (lsr_rd_i),
    .msr_rd_i     (msr_rd_i),
    .thr_wr_i     (thr_wr_i),
    .irq_o        (irq_o),
    .iir_o        (iir_o)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] ier = '0;
    logic fifo_en = 0, lerr = 0, rxa = 0, tmo = 0, thre = 0, mdel = 0;
    logic rbr_rd = 0, lsr_rd = 0, msr_rd = 0, iir_rd = 0, thr_wr = 0;
    logic irq;
    logic [7:0] iir;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst_n(rst_n), .ier_i(ier), .fifo_en_i(fifo_en),
        .lsr_err_i(lerr), .rx_avail_i(rxa), .rx_timeout_i(tmo),
        .thr_empty_i(thre), .msr_delta_i(mdel), .rbr_rd_i(rbr_rd),
        .lsr_rd_i(lsr_rd), .msr_rd_i(msr_rd), .iir_rd_i(iir_rd),
        .thr_wr_i(thr_wr), .irq_o(irq), .iir_o(iir)
    );

    // Reference event model built from the requirements
    logic m_l, m_r, m_t, m_h, m_m;
    logic p_l, p_r, p_t, p_h, p_m, p_en1;

    function automatic logic [7:0] exp_id();
        logic [2:0] c;
        logic a;
        a = 1'b1;
        if (m_l && ier[2])      c = 3'b011;
        else if (m_r && ier[0]) c = 3'b010;
        else if (m_t && ier[0]) c = 3'b110;
        else if (m_h && ier[1]) c = 3'b001;
        else if (m_m && ier[3]) c = 3'b000;
        else begin c = 3'b000; a = 1'b0; end
        return {fifo_en, fifo_en, 2'b00, c, ~a};
    endfunction

    always @(posedge clk) begin
        logic [7:0] e;
        e = exp_id();
        if (!rst_n) begin
            {m_l, m_r, m_t, m_h, m_m} <= '0;
            {p_l, p_r, p_t, p_h, p_m, p_en1} <= '0;
        end else begin
            m_l <= (lerr & ~p_l) | (m_l & ~lsr_rd);
            m_r <= (rxa & ~p_r) | (m_r & ~rbr_rd);
            m_t <= (tmo & ~p_t) | (m_t & ~rbr_rd);
            m_m <= (mdel & ~p_m) | (m_m & ~msr_rd);
            m_h <= (thre & ~p_h) | (thre & ier[1] & ~p_en1)
                 | (m_h & ~(thr_wr | (iir_rd && e[3:0] == 4'b0010)));
            p_l <= lerr; p_r <= rxa; p_t <= tmo; p_h <= thre; p_m <= mdel;
            p_en1 <= ier[1];
        end
    end

    task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        chk8(tag, iir, exp_id());
        chk8({tag, " irq"}, {7'd0, irq}, {7'd0, ~exp_id() & 8'h01});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        repeat (3) @(negedge clk);
        chk8("R2 reset id", iir, 8'h01);
        chk8("R2 reset irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc("R2 after reset");
        fifo_en = 1'b1;
        #1 chk8("R7 fifo bits", iir, 8'hC1);
        ier = 4'hF;
        lerr = 1; cyc("R3 line");
        chk8("R3 line code", iir, 8'hC6);
        chk8("R1 irq", {7'd0, irq}, 8'h01);
        rxa = 1; cyc("R8 line over rx");
        chk8("R8 line over rx code", iir, 8'hC6);
        lsr_rd = 1; cyc("R4 line read"); lsr_rd = 0;
        chk8("R4 line cleared", iir, 8'hC4);
        thre = 1; cyc("R8 rx over thr");
        chk8("R8 rx over thr code", iir, 8'hC4);
        rxa = 0; rbr_rd = 1; cyc("R5 rx read"); rbr_rd = 0;
        chk8("R5 rx cleared", iir, 8'hC2);
        iir_rd = 1;
        #1 chk8("R11 id before clear", iir, 8'hC2);
        cyc("R6 id read"); iir_rd = 0;
        chk8("R6 thr cleared by id read", iir, 8'hC1);
        mdel = 1; cyc("R3 modem");
        chk8("R3 modem code", iir, 8'hC0);
        mdel = 0; msr_rd = 1; cyc("R4 modem read"); msr_rd = 0;
        chk8("R4 modem cleared", iir, 8'hC1);
        tmo = 1; cyc("R3 timeout");
        chk8("R3 timeout code", iir, 8'hCC);
        tmo = 0; rbr_rd = 1; cyc("R5 timeout read"); rbr_rd = 0;
        chk8("R5 timeout cleared", iir, 8'hC1);
        ier = 4'h0; cyc("R10 disable");
        ier = 4'h2; cyc("R10 enable rearm");
        chk8("R10 rearm code", iir, 8'hC2);
        thr_wr = 1; thre = 0; cyc("R6 write"); thr_wr = 0;
        chk8("R6 thr cleared by write", iir, 8'hC1);
        ier = 4'h0; lerr = 0; cyc("R9 low");
        lerr = 1; cyc("R1 masked");
        chk8("R1 masked irq", {7'd0, irq}, 8'h00);
        ier = 4'h4; cyc("R9 held while masked");
        chk8("R9 held code", iir, 8'hC6);
        lerr = 0; cyc("R9 low again");
        lerr = 1; lsr_rd = 1; cyc("R9 rise beats clear"); lsr_rd = 0;
        chk8("R9 rise beats clear code", iir, 8'hC6);
        lsr_rd = 1; cyc("R4 final clear"); lsr_rd = 0;
        rs = 32'h1234_5678;
        for (int k = 0; k < 4000; k++) begin
            rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
            ier = rs[3:0]; fifo_en = rs[4];
            lerr = rs[5]; rxa = rs[6]; tmo = rs[7]; thre = rs[8]; mdel = rs[9];
            rbr_rd = rs[10] & rs[11]; lsr_rd = rs[12] & rs[13];
            msr_rd = rs[14] & rs[15]; iir_rd = rs[16] & rs[17];
            thr_wr = rs[18] & rs[19];
            #1 chk8("R11 pre-edge id", iir, exp_id());
            cyc("R8 sweep");
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule